// File: doc/BRIEF.md
# Multiframe Subchannel Nibble Exchange

This block moves two 4-bit subchannel values between a host and a line framer once per multiframe. It runs in one of two directions, chosen by a mode pin.

On the network side (mode pin low), the host writes an 8-bit register. At each multiframe boundary the block copies that register into a transmit latch. The framer sends the latch contents for the whole multiframe. If the host has not written since the last boundary, the same nibbles go out again.

On the terminal side (mode pin high), the framer presents the two nibbles it extracted. The block captures them at each boundary into the same register, which the host can then read but not write. Boundaries are marked by a one-cycle strobe from the framer, which also sets the multiframe period (nominally 5 ms). An optional sticky interrupt flag marks each boundary, and the host clears it by writing a one.

A small state machine tracks the operating condition:
- `ST_OFF`: multiframing is disabled.
- `ST_NT_RUN`: network-side exchange is active.
- `ST_TE_RUN`: terminal-side exchange is active.

The named transitions are:
- `T_ENABLE_NT` (`ST_OFF`→`ST_NT_RUN`): enable high, mode low.
- `T_ENABLE_TE` (`ST_OFF`→`ST_TE_RUN`): enable high, mode high.
- `T_DISABLE` (either run state→`ST_OFF`): enable low, or software reset.
- `T_TO_TE` (`ST_NT_RUN`→`ST_TE_RUN`): mode rises while enabled.
- `T_TO_NT` (`ST_TE_RUN`→`ST_NT_RUN`): mode falls while enabled.

Every other case holds the current state.

Top module: `mfsub_xchg`

## Requirements
- R1: After a hardware reset (`rst_n` low) or a one-cycle `soft_rst` pulse, all of the following are zero: the register, the transmit latch, the transmit outputs and the interrupt flag. The state is `ST_OFF`.
- R2: Register packing: subchannel 4 is held in bits 7:4 and subchannel 5 in bits 3:0. In each nibble the highest bit is the MSB. `tx_nib_hi` carries bits 7:4 of the latch and `tx_nib_lo` carries bits 3:0. Bits 7:4 of the register are loaded from `rx_nib_hi` and bits 3:0 from `rx_nib_lo`.
- R3: In `ST_NT_RUN`, a boundary strobe copies the register value held before that edge into the latch. The new value appears on the transmit outputs in the next cycle. A host write made in the same cycle as the strobe is sent only at the following boundary.
- R4: In `ST_NT_RUN`, with no host write, the transmit outputs keep their value across further boundaries (stale data is resent unchanged).
- R5: With the mode pin low, a read of the data register (`host_sel`=0) returns zero.
- R6: In `ST_TE_RUN`, a boundary strobe loads `{rx_nib_hi, rx_nib_lo}` into the register. Reads of the data register return it. Changes of the receive inputs between boundaries have no effect.
- R7: With the mode pin high, host writes to the data register are ignored.
- R8: In `ST_OFF`, boundary strobes neither load the latch, nor capture receive data, nor set the interrupt flag, and both transmit outputs are zero.
- R9: With `irq_enable` high, a boundary strobe in a run state sets the interrupt flag. The flag is read as bit 0 at `host_sel`=1 and stays set until the host writes `host_sel`=1 with bit 0 set. If a set and a clear happen in the same cycle, the set wins.
- R10: A change of the mode pin clears the register and the transmit latch in the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset |
| mf_enable | input | 1 | Multiframing enable |
| mode_te | input | 1 | 0 = network side, 1 = terminal side |
| irq_enable | input | 1 | Allows the boundary interrupt flag to be set |
| mf_start | input | 1 | One-cycle multiframe boundary strobe |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 = data register, 1 = interrupt status |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| rx_nib_hi | input | 4 | Received subchannel 4 nibble from framer |
| rx_nib_lo | input | 4 | Received subchannel 5 nibble from framer |
| tx_nib_hi | output | 4 | Subchannel 4 nibble to framer |
| tx_nib_lo | output | 4 | Subchannel 5 nibble to framer |
| irq | output | 1 | Sticky boundary interrupt |

## Verification
The hardest situation to reach is a host write that coincides with a boundary strobe in `ST_NT_RUN`. The register must take the new value while the latch takes the old one. The bench drives both strobes in the same cycle and checks the outputs across two boundaries.

Mode flips followed by a boundary are also hard to reach. The bench loads a known latch value, toggles the mode twice, and shows through the transmit outputs that the latch was emptied. All 256 register values are swept in both directions.

// File: rtl/mfx_pkg.sv
package mfx_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_NT_RUN = 2'd1,
        ST_TE_RUN = 2'd2
    } mfx_state_t;
endpackage

// File: rtl/mfx_ctrl.sv
module mfx_ctrl
    import mfx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       mf_enable,
    input  logic       mode_te,
    output mfx_state_t state_o,
    output logic       flip_o,
    output logic       run_o
);
    mfx_state_t state_q, state_d;
    logic       mode_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (mf_enable && !soft_rst)
                    state_d = mode_te ? ST_TE_RUN : ST_NT_RUN;   // T_ENABLE_TE / T_ENABLE_NT
            end
            ST_NT_RUN: begin
                if (!mf_enable || soft_rst) state_d = ST_OFF;    // T_DISABLE
                else if (mode_te)           state_d = ST_TE_RUN; // T_TO_TE
            end
            ST_TE_RUN: begin
                if (!mf_enable || soft_rst) state_d = ST_OFF;    // T_DISABLE
                else if (!mode_te)          state_d = ST_NT_RUN; // T_TO_NT
            end
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_te;
        end
    end

    // outputs
    always_comb begin
        state_o = state_q;
        flip_o  = (mode_te != mode_q);
        run_o   = (state_q != ST_OFF);
    end

    a_r8_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_enable |=> state_q == ST_OFF);
    a_r1_soft_to_off: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> state_q == ST_OFF);
endmodule

// File: rtl/mfx_regfile.sv
module mfx_regfile
    import mfx_pkg::*;
#(
    parameter int NIB_W = 4,
    localparam int REG_W = 2 * NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             flip,
    input  logic             mode_te,
    input  mfx_state_t       state,
    input  logic             mf_start,
    input  logic             host_we,
    input  logic             host_sel,
    input  logic [REG_W-1:0] host_wdata,
    input  logic [REG_W-1:0] rx_packed,
    output logic [REG_W-1:0] shadow_o,
    output logic [REG_W-1:0] latch_o
);
    logic [REG_W-1:0] shadow_q, latch_q;
    logic             nt_boundary, te_boundary, clr;

    assign nt_boundary = mf_start && (state == ST_NT_RUN);
    assign te_boundary = mf_start && (state == ST_TE_RUN);
    assign clr         = soft_rst || flip;

    // host-facing register: direction follows the mode pin
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            shadow_q <= '0;
        else if (clr)                          shadow_q <= '0;
        else if (mode_te) begin
            if (te_boundary)                   shadow_q <= rx_packed;
        end else if (host_we && !host_sel)     shadow_q <= host_wdata;
    end

    // transmit latch: loaded only at a network-side boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           latch_q <= '0;
        else if (clr)         latch_q <= '0;
        else if (nt_boundary) latch_q <= shadow_q;
    end

    assign shadow_o = shadow_q;
    assign latch_o  = latch_q;

    a_r3_sample_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        nt_boundary && !clr |=> latch_q == $past(shadow_q));
    a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !nt_boundary && !clr |=> $stable(latch_q));
    a_r6_capture_rx: assert property (@(posedge clk) disable iff (!rst_n)
        te_boundary && mode_te && !clr |=> shadow_q == $past(rx_packed));
    a_r7_te_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        mode_te && !mf_start && !clr |=> $stable(shadow_q));
    a_r10_flip_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flip |=> (shadow_q == '0) && (latch_q == '0));
endmodule

// File: rtl/mfx_irq.sv
module mfx_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (soft_rst) flag_q <= 1'b0;
        else if (set_i)    flag_q <= 1'b1;
        else if (clr_i)    flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_i && !soft_rst |=> flag_q);
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q && !clr_i && !soft_rst |=> flag_q);
    a_r1_soft_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !flag_q);
endmodule

// File: rtl/mfsub_xchg.sv
module mfsub_xchg
    import mfx_pkg::*;
#(
    parameter int NIB_W = 4,
    localparam int REG_W = 2 * NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             mf_enable,
    input  logic             mode_te,
    input  logic             irq_enable,
    input  logic             mf_start,
    input  logic             host_we,
    input  logic             host_sel,
    input  logic [REG_W-1:0] host_wdata,
    output logic [REG_W-1:0] host_rdata,
    input  logic [NIB_W-1:0] rx_nib_hi,
    input  logic [NIB_W-1:0] rx_nib_lo,
    output logic [NIB_W-1:0] tx_nib_hi,
    output logic [NIB_W-1:0] tx_nib_lo,
    output logic             irq
);
    mfx_state_t       state;
    logic             flip, run, flag;
    logic [REG_W-1:0] rx_packed, shadow, latch;

    // nibble packing: subchannel 4 high, subchannel 5 low
    for (genvar b = 0; b < NIB_W; b++) begin : g_pack
        assign rx_packed[NIB_W + b] = rx_nib_hi[b];
        assign rx_packed[b]         = rx_nib_lo[b];
        assign tx_nib_hi[b] = (state == ST_NT_RUN) ? latch[NIB_W + b] : 1'b0;
        assign tx_nib_lo[b] = (state == ST_NT_RUN) ? latch[b]         : 1'b0;
    end

    mfx_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .mf_enable (mf_enable),
        .mode_te   (mode_te),
        .state_o   (state),
        .flip_o    (flip),
        .run_o     (run)
    );

    mfx_regfile #(.NIB_W(NIB_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .flip       (flip),
        .mode_te    (mode_te),
        .state      (state),
        .mf_start   (mf_start),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .rx_packed  (rx_packed),
        .shadow_o   (shadow),
        .latch_o    (latch)
    );

    mfx_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .set_i    (mf_start && irq_enable && run),
        .clr_i    (host_we && host_sel && host_wdata[0]),
        .flag_o   (flag)
    );

    assign irq = flag;

    always_comb begin
        if (host_sel)     host_rdata = {{(REG_W-1){1'b0}}, flag};
        else if (mode_te) host_rdata = shadow;
        else              host_rdata = '0;
    end

    a_r8_tx_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_NT_RUN |-> (tx_nib_hi == '0) && (tx_nib_lo == '0));
    a_r8_no_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !flag |=> !flag);
endmodule

// File: tb/test_mfsub_xchg.sv
`timescale 1ns/1ps
module test_mfsub_xchg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, soft_rst = 1'b0, mf_enable = 1'b0, mode_te = 1'b0;
    logic       irq_enable = 1'b0, mf_start = 1'b0, host_we = 1'b0, host_sel = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [3:0] rx_nib_hi = 4'h0, rx_nib_lo = 4'h0;
    logic [3:0] tx_nib_hi, tx_nib_lo;
    logic       irq;
    int         total = 0, bad = 0;
    logic       finished = 1'b0;

    always #2.5 clk = ~clk;

    mfsub_xchg i_mfsub_xchg (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .mf_enable(mf_enable),
        .mode_te(mode_te), .irq_enable(irq_enable), .mf_start(mf_start),
        .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .rx_nib_hi(rx_nib_hi), .rx_nib_lo(rx_nib_lo),
        .tx_nib_hi(tx_nib_hi), .tx_nib_lo(tx_nib_lo), .irq(irq)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        step();
        host_we = 1'b0; host_sel = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        host_sel = sel;
        #0.5;
        d = host_rdata;
        host_sel = 1'b0;
    endtask

    task automatic boundary();
        mf_start = 1'b1;
        step();
        mf_start = 1'b0;
    endtask

    function automatic logic [7:0] txv();
        return {tx_nib_hi, tx_nib_lo};
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        step(); step();
        rst_n = 1'b1;
        step();
        // R1: hardware reset state
        check("R1 tx after reset", txv(), 8'h00);
        check("R1 irq after reset", {7'b0, irq}, 8'h00);
        rd(1'b1, r); check("R1 status after reset", r, 8'h00);

        // R2 R3 R5: network-side sweep of every value
        mf_enable = 1'b1;
        step();
        for (int v = 0; v < 256; v++) begin
            logic [7:0] prev;
            prev = txv();
            wr(1'b0, v[7:0]);
            check("R3 tx unchanged before boundary", txv(), prev);
            rd(1'b0, r); check("R5 nt read zero", r, 8'h00);
            boundary();
            check("R3 tx after boundary", txv(), v[7:0]);
            check("R2 subchannel 4 in high nibble", {4'h0, tx_nib_hi}, {4'h0, v[7:4]});
            if (v % 16 == 5) begin
                boundary(); boundary();
                check("R4 stale resend", txv(), v[7:0]);
            end
        end

        // R3: write coinciding with boundary goes out one boundary later
        wr(1'b0, 8'h3C);
        host_we = 1'b1; host_sel = 1'b0; host_wdata = 8'hA5; mf_start = 1'b1;
        step();
        host_we = 1'b0; mf_start = 1'b0;
        check("R3 same-cycle write not sent", txv(), 8'h3C);
        boundary();
        check("R3 same-cycle write sent next", txv(), 8'hA5);

        // R9: interrupt flag
        irq_enable = 1'b1;
        boundary();
        check("R9 irq set", {7'b0, irq}, 8'h01);
        step(); step();
        rd(1'b1, r); check("R9 irq sticky", r, 8'h01);
        wr(1'b1, 8'hFE);
        check("R9 write without bit0 keeps", {7'b0, irq}, 8'h01);
        wr(1'b1, 8'h01);
        check("R9 w1c clears", {7'b0, irq}, 8'h00);
        host_we = 1'b1; host_sel = 1'b1; host_wdata = 8'h01; mf_start = 1'b1;
        step();
        host_we = 1'b0; host_sel = 1'b0; mf_start = 1'b0;
        check("R9 set wins over clear", {7'b0, irq}, 8'h01);
        wr(1'b1, 8'h01);
        irq_enable = 1'b0;
        boundary();
        check("R9 no set when disabled", {7'b0, irq}, 8'h00);

        // R8: multiframing off
        irq_enable = 1'b1;
        mf_enable = 1'b0;
        step();
        wr(1'b0, 8'h77);
        check("R8 tx zero when off", txv(), 8'h00);
        boundary();
        check("R8 tx zero after strobe off", txv(), 8'h00);
        check("R8 no irq when off", {7'b0, irq}, 8'h00);
        irq_enable = 1'b0;
        mf_enable = 1'b1;
        step();
        check("R8 latch not loaded while off", txv(), 8'hA5);
        boundary();
        check("R8 resumed exchange", txv(), 8'h77);

        // R10: mode flip clears register and latch
        mode_te = 1'b1;
        step(); step();
        rd(1'b0, r); check("R10 register cleared on flip", r, 8'h00);
        check("R8 tx zero in terminal mode", txv(), 8'h00);

        // R6 R7: terminal-side sweep
        for (int v = 0; v < 256; v++) begin
            rx_nib_hi = v[7:4]; rx_nib_lo = v[3:0];
            boundary();
            rd(1'b0, r); check("R6 captured nibbles", r, v[7:0]);
            rx_nib_hi = ~v[7:4]; rx_nib_lo = ~v[3:0];
            wr(1'b0, 8'h5A);
            step();
            rd(1'b0, r); check("R7 write ignored and rx held", r, v[7:0]);
        end

        // R1: software reset
        irq_enable = 1'b1;
        boundary();
        irq_enable = 1'b0;
        soft_rst = 1'b1;
        step();
        soft_rst = 1'b0;
        rd(1'b0, r); check("R1 soft reset clears register", r, 8'h00);
        check("R1 soft reset clears irq", {7'b0, irq}, 8'h00);
        step();

        // R10: latch emptied across a double mode flip
        mode_te = 1'b0;
        step(); step();
        wr(1'b0, 8'hC3);
        boundary();
        check("R10 setup latch", txv(), 8'hC3);
        mode_te = 1'b1; step(); step();
        mode_te = 1'b0; step(); step();
        check("R10 latch cleared", txv(), 8'h00);
        boundary();
        check("R10 register cleared before boundary", txv(), 8'h00);

        finish_run();
    end
endmodule